// File: doc/BRIEF.md
# Dynamic-Bus to 16-bit Peripheral Strobe Adapter

This block sits between a processor that has a 32-bit dynamically sized bus and a peripheral bus 16 bits wide with separate byte-lane strobes. The processor gives an active-low data strobe, address bit zero and a two-bit transfer-size code. From these the block builds an active-low upper-lane strobe and an active-low lower-lane strobe for the peripheral. A byte strobe asserts only after the processor strobe has been seen low at a rising clock edge. A flip-flop holds that delayed copy, and it returns high at once, without waiting for a clock, when the processor strobe is released.

On the return path the peripheral's active-low transfer acknowledge goes through a synchronizer chain. A small state machine turns it into the processor's two-bit port-size acknowledge. The block always reports a 16-bit port: the upper acknowledge bit goes low and the lower one stays high. The state machine has five states. IDLE waits for the processor strobe. ARMED covers the cycle in which the strobe is low but not yet qualified. WAIT holds the byte strobes active until the synchronized acknowledge arrives. ACK drives the port-size acknowledge. DRAIN waits for the peripheral's acknowledge to be seen high again before a new cycle may complete.

The transitions are as follows. IDLE goes to ARMED when the strobe goes low. ARMED goes to WAIT if the strobe is still low and back to IDLE if it is high. WAIT goes to ACK when the synchronized acknowledge is low and to IDLE if the strobe rises. ACK goes to DRAIN when the strobe rises. DRAIN goes to IDLE once the synchronized acknowledge is high. Interrupt-acknowledge cycles use exactly the same path. A peripheral that never sees its lane strobe never acknowledges, so such a cycle hangs instead of completing falsely.

Top module: `strobe_adapter`

## Requirements
- R1: While reset is held and right after it, both lane strobes and both acknowledge outputs are high.
- R2: While the processor strobe `cpu_ds_n` is high, both lane strobes are high, whatever the values of `addr0` and `siz`.
- R3: A lane strobe stays high until the first rising clock edge at which `cpu_ds_n` is sampled low. The lane strobes return high in the same cycle in which `cpu_ds_n` rises, without waiting for a clock edge.
- R4: Once the strobe is qualified, `uds_n` is low exactly when `addr0` is 0.
- R5: Once the strobe is qualified, `lds_n` is low unless `addr0`=0 and `siz`=2'b01. The size code is 01 for a byte, 10 for a word, 11 for three bytes and 00 for four bytes.
- R6: A byte transfer at an odd address (`addr0`=1, `siz`=01) gives `lds_n` low and `uds_n` high. A word transfer at an even address (`addr0`=0, `siz`=10) gives both strobes low.
- R7: `dtack_n` passes through SYNC_STAGES flip-flops (default 2). With the cycle in WAIT, `dsack1_n` goes low at the third rising edge after `dtack_n` falls. `dsack0_n` stays high throughout, which signals a 16-bit port.
- R8: When `dtack_n` stays high, `dsack1_n` stays high however long the strobe is held, so the cycle hangs instead of completing.
- R9: `dsack1_n` goes high in the same cycle in which `cpu_ds_n` rises.
- R10: After a completed cycle, a new strobe is not acknowledged while the synchronized `dtack_n` is still low. It completes only after `dtack_n` has been seen high and then falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ds_n | input | 1 | Processor data strobe, active low |
| addr0 | input | 1 | Address bit zero |
| siz | input | 2 | Transfer-size code, active high |
| dtack_n | input | 1 | Peripheral transfer acknowledge, active low |
| uds_n | output | 1 | Upper byte-lane strobe, active low |
| lds_n | output | 1 | Lower byte-lane strobe, active low |
| dsack0_n | output | 1 | Port-size acknowledge bit 0, active low |
| dsack1_n | output | 1 | Port-size acknowledge bit 1, active low |

## Verification
The bench sweeps all eight combinations of address bit and size code. It checks each one in the idle phase, in the unqualified first cycle and in the qualified phase. A design with an inverted lower-strobe condition would leave `lds_n` high on an odd byte access. An interrupt-acknowledge cycle would then hang. The bench times the acknowledge against the synchronizer depth, so an extra or missing stage shows up as an early or late `dsack1_n`. It holds a stale acknowledge low across the start of a new strobe, which catches a design that completes the next cycle on leftover state. A run with no acknowledge at all confirms that the cycle hangs rather than completing.

// File: rtl/strobe_adapter_pkg.sv
package strobe_adapter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_WAIT  = 3'd2,
        ST_ACK   = 3'd3,
        ST_DRAIN = 3'd4
    } ack_state_t;

    localparam logic [1:0] SIZ_LONG  = 2'b00;
    localparam logic [1:0] SIZ_BYTE  = 2'b01;
    localparam logic [1:0] SIZ_WORD  = 2'b10;
    localparam logic [1:0] SIZ_TRIPLE = 2'b11;

endpackage

// File: rtl/ds_qualifier.sv
module ds_qualifier (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_ds_n,
    output logic ds_dly_n
);

    // Samples the strobe on rising edges; forced high asynchronously
    // whenever the strobe is released.
    always_ff @(posedge clk or negedge rst_n or posedge cpu_ds_n) begin
        if (!rst_n) begin
            ds_dly_n <= 1'b1;
        end else if (cpu_ds_n) begin
            ds_dly_n <= 1'b1;
        end else begin
            ds_dly_n <= 1'b0;
        end
    end

    a_r3_dly_released: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ds_n |-> ds_dly_n);

    a_r3_dly_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ds_n && $past(!cpu_ds_n)) |-> !ds_dly_n);

endmodule

// File: rtl/dtack_sync.sv
module dtack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dtack_n,
    output logic dtack_sync_n
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= dtack_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dtack_sync_n = chain_q[LAST];

endmodule

// File: rtl/lane_decode.sv
module lane_decode
    import strobe_adapter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_ds_n,
    input  logic       ds_dly_n,
    input  logic       addr0,
    input  logic [1:0] siz,
    output logic       uds_n,
    output logic       lds_n
);

    logic qualified;
    logic even_byte;

    always_comb begin
        qualified = !cpu_ds_n && !ds_dly_n;
        even_byte = !addr0 && (siz == SIZ_BYTE);
        uds_n     = !(qualified && !addr0);
        lds_n     = !(qualified && !even_byte);
    end

    a_r2_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ds_n |-> (uds_n && lds_n));

    a_r3_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
        ds_dly_n |-> (uds_n && lds_n));

    a_r4_odd_no_upper: assert property (@(posedge clk) disable iff (!rst_n)
        addr0 |-> uds_n);

    a_r5_even_byte_no_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr0 && siz == SIZ_BYTE) |-> lds_n);

endmodule

// File: rtl/ack_fsm.sv
module ack_fsm
    import strobe_adapter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_ds_n,
    input  logic dtack_sync_n,
    output logic dsack0_n,
    output logic dsack1_n
);

    ack_state_t state_q;
    ack_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cpu_ds_n) state_d = ST_ARMED;
            ST_ARMED: state_d = cpu_ds_n ? ST_IDLE : ST_WAIT;
            ST_WAIT: begin
                if (cpu_ds_n)           state_d = ST_IDLE;
                else if (!dtack_sync_n) state_d = ST_ACK;
            end
            ST_ACK:   if (cpu_ds_n) state_d = ST_DRAIN;
            ST_DRAIN: if (dtack_sync_n) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        dsack0_n = 1'b1;
        dsack1_n = !(state_q == ST_ACK) || cpu_ds_n;
    end

    a_r7_ack_after_dtack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK && $past(state_q) != ST_ACK) |-> !$past(dtack_sync_n));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ds_n |-> dsack1_n);

    a_r10_ack_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK) |-> ($past(state_q) == ST_WAIT || $past(state_q) == ST_ACK));

    a_r7_port16: assert property (@(posedge clk) disable iff (!rst_n)
        !dsack1_n |-> dsack0_n);

endmodule

// File: rtl/strobe_adapter.sv
module strobe_adapter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_ds_n,
    input  logic       addr0,
    input  logic [1:0] siz,
    input  logic       dtack_n,
    output logic       uds_n,
    output logic       lds_n,
    output logic       dsack0_n,
    output logic       dsack1_n
);

    logic ds_dly_n;
    logic dtack_sync_n;

    ds_qualifier u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_ds_n (cpu_ds_n),
        .ds_dly_n (ds_dly_n)
    );

    lane_decode u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_ds_n (cpu_ds_n),
        .ds_dly_n (ds_dly_n),
        .addr0    (addr0),
        .siz      (siz),
        .uds_n    (uds_n),
        .lds_n    (lds_n)
    );

    dtack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .dtack_n      (dtack_n),
        .dtack_sync_n (dtack_sync_n)
    );

    ack_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_ds_n     (cpu_ds_n),
        .dtack_sync_n (dtack_sync_n),
        .dsack0_n     (dsack0_n),
        .dsack1_n     (dsack1_n)
    );

endmodule

// File: tb/strobe_adapter_tb.sv
module strobe_adapter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_ds_n = 1'b1;
    logic       addr0 = 1'b0;
    logic [1:0] siz = 2'b00;
    logic       dtack_n = 1'b1;
    logic       uds_n, lds_n, dsack0_n, dsack1_n;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    strobe_adapter u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_ds_n(cpu_ds_n), .addr0(addr0),
        .siz(siz), .dtack_n(dtack_n), .uds_n(uds_n), .lds_n(lds_n),
        .dsack0_n(dsack0_n), .dsack1_n(dsack1_n)
    );

    // Outputs packed as {uds_n, lds_n, dsack1_n, dsack0_n}
    task automatic chk(input string req, input logic [3:0] expv);
        logic [3:0] act;
        act = {uds_n, lds_n, dsack1_n, dsack0_n};
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: {uds,lds,dsack1,dsack0} actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    function automatic logic [1:0] lanes_exp(input logic a0, input logic [1:0] sz);
        logic u, l;
        u = a0;
        l = (!a0 && sz == 2'b01);
        return {u, l};
    endfunction

    initial begin
        #1_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1 reset
        #12;
        settle();
        chk("R1 during reset", 4'b1111);
        tick(); tick();
        rst_n = 1'b1;
        settle();
        chk("R1 after reset", 4'b1111);
        tick();

        // R2..R6: sweep every addr0/siz combination
        for (int c = 0; c < 8; c++) begin
            logic [1:0] le;
            addr0 = c[2];
            siz   = c[1:0];
            settle();
            chk($sformatf("R2 idle a0=%0b siz=%02b", addr0, siz), 4'b1111);
            tick();
            cpu_ds_n = 1'b0;
            settle();
            chk($sformatf("R3 unqualified a0=%0b siz=%02b", addr0, siz), 4'b1111);
            tick();
            settle();
            le = lanes_exp(addr0, siz);
            chk($sformatf("R4 R5 qualified a0=%0b siz=%02b", addr0, siz), {le, 2'b11});
            tick();
            settle();
            chk($sformatf("R4 R5 held a0=%0b siz=%02b", addr0, siz), {le, 2'b11});
            cpu_ds_n = 1'b1;
            settle();
            chk($sformatf("R3 async release a0=%0b siz=%02b", addr0, siz), 4'b1111);
            tick(); tick();
        end

        // R6 explicit cases
        addr0 = 1'b1; siz = 2'b01;
        cpu_ds_n = 1'b0;
        tick(); settle();
        chk("R6 odd byte", 4'b1011);
        cpu_ds_n = 1'b1;
        tick(); tick();
        addr0 = 1'b0; siz = 2'b10;
        cpu_ds_n = 1'b0;
        tick(); settle();
        chk("R6 even word", 4'b0011);

        // R7: DTACK-terminated word cycle
        tick(); tick();
        dtack_n = 1'b0;
        tick(); tick(); settle();
        chk("R7 not yet acknowledged", 4'b0011);
        tick(); settle();
        chk("R7 acknowledge as 16-bit port", 4'b0001);
        tick(); settle();
        chk("R7 acknowledge held", 4'b0001);

        // R9: release, then R10: stale acknowledge across a new strobe
        cpu_ds_n = 1'b1;
        settle();
        chk("R9 release with strobe", 4'b1111);
        tick();
        cpu_ds_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tick(); settle();
            chk("R10 stale dtack ignored", 4'b0011);
        end
        dtack_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick();
        end
        settle();
        chk("R10 waiting after drain", 4'b0011);
        dtack_n = 1'b0;
        tick(); tick(); settle();
        chk("R10 not early", 4'b0011);
        tick(); settle();
        chk("R10 fresh dtack completes", 4'b0001);
        cpu_ds_n = 1'b1;
        settle();
        chk("R9 release again", 4'b1111);
        tick();
        dtack_n = 1'b1;
        for (int k = 0; k < 5; k++) tick();

        // R8: interrupt-acknowledge style cycle where the peripheral never answers
        addr0 = 1'b0; siz = 2'b01;
        cpu_ds_n = 1'b0;
        for (int k = 0; k < 20; k++) begin
            tick(); settle();
            chk("R8 no dtack hangs", 4'b0111);
        end
        cpu_ds_n = 1'b1;
        tick(); tick();

        // R6 R7: odd byte acknowledge cycle answered by a peripheral on LDS
        addr0 = 1'b1; siz = 2'b01;
        cpu_ds_n = 1'b0;
        tick(); settle();
        chk("R6 iack lower lane", 4'b1011);
        tick();
        dtack_n = lds_n;
        tick(); tick(); tick(); settle();
        chk("R7 iack completes", 4'b1001);
        cpu_ds_n = 1'b1;
        settle();
        chk("R9 iack release", 4'b1111);
        tick();
        dtack_n = 1'b1;
        tick();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule